// File: doc/BRIEF.md
# DMA Register Block with Per-Master Write Filtering

This block holds the programming registers of a four-sub-channel DMA controller: one 16-bit band control register shared by all sub-channels, an 8-bit control register per sub-channel, and a memory-address, I/O-address and transfer-count register per sub-channel. Two bus masters share a single register write port: the CPU and a secondary transfer engine. A sideband tag on every write says which of them issued it.

CPU writes always land in full. Transfer-engine writes are filtered bit by bit by a 4-bit write-enable register. Each enable bit belongs to one sub-channel and opens that sub-channel's control register and its three columns of the band register. The engine can never change the band register's mode bits. When a channel is in full-address mode, the engine can change that channel's band bits only if both of the channel's enables are set. The registers are read back through a combinational read port.

Sub-channels are numbered k = 0 (0A), 1 (0B), 2 (1A) and 3 (1B). Channel c covers sub-channels 2c and 2c+1.

Top module: `dma_regguard`

## Requirements
- R1: After reset every register reads 0. Address map: 0 is the band register, 1 the write-enable register, 2+k the control register of sub-channel k, and 8+3k, 9+3k and 10+3k the memory-address, I/O-address and count registers of sub-channel k. Narrower registers read zero-extended.
- R2: The write-enable register stores data bits 3:0, where bit k belongs to sub-channel k. Bits 7:4 always read 0, whatever value is written to them.
- R3: A transfer-engine write (wr_eng=1) to the control register of sub-channel k replaces it only when enable bit k is 1. Otherwise the register keeps its value.
- R4: A transfer-engine write to band bit b (b in 0..11) takes effect only when sub-channel k = b mod 4 is permitted. Denied bits keep their value, and permitted bits of the same write update.
- R5: Band bit 14 puts channel 0 in full-address mode and band bit 15 does the same for channel 1. While a channel is in this mode, its sub-channels are permitted for band writes only if enable bits 2c and 2c+1 are both 1. Otherwise a sub-channel is permitted when its own enable bit is 1.
- R6: Band bits 15:12 (the full-address and source-mode bits) are never changed by a transfer-engine write.
- R7: CPU writes (wr_eng=0) update every implemented bit of any register, whatever the enables are set to.
- R8: Address and count registers accept writes from either master, whatever the enables are set to.
- R9: Transfer-engine writes to the write-enable register are ignored.
- R10: When sub-channel k is permitted, a single transfer-engine write of 1 sets the transfer-enable bit, band bit 4+k. No earlier access is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_eng | input | 1 | Master tag: 1 means transfer engine, 0 means CPU |
| wr_addr | input | AW | Write register address |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read register address |
| rd_data | output | DW | Read data (combinational) |

## Verification
A wrong permission mask shows up on the next read after a single engine write. Its signature is a band or control bit that holds when it should have changed, or changes when it should have held. The full-address rule is the delicate case. A stale or miswired channel mode bit allows a reactivation with only one enable set, and the bench sweeps every enable and mode pattern so that this is caught. An error in the write-enable register appears one cycle after the CPU write, either as a nonzero reserved bit or as an engine write that was accepted.

// File: rtl/dma_rg_pkg.sv
package dma_rg_pkg;
  localparam int NSUB   = 4;
  localparam int BAND_W = 16;
  localparam int WEN_W  = 8;
  localparam int A_BAND  = 0;
  localparam int A_WEN   = 1;
  localparam int A_CTRL0 = 2;
  localparam int A_XFER0 = 8;
  localparam int XREGS   = 3;

  // sub-channel permission for engine band writes
  function automatic logic [NSUB-1:0] sub_perm(input logic [NSUB-1:0] en,
                                               input logic [1:0] fa);
    logic [NSUB-1:0] p;
    for (int k = 0; k < NSUB; k++) begin
      logic both;
      both = en[(k/2)*2] & en[(k/2)*2+1];
      p[k] = en[k] & (~fa[k/2] | both);
    end
    return p;
  endfunction

  // engine-writable band bits: columns 11:0, mode bits never
  function automatic logic [BAND_W-1:0] band_eng_mask(input logic [NSUB-1:0] p);
    logic [BAND_W-1:0] m;
    m = '0;
    for (int b = 0; b < 12; b++) m[b] = p[b % NSUB];
    return m;
  endfunction

  function automatic logic [BAND_W-1:0] merge16(input logic [BAND_W-1:0] old_v,
                                                input logic [BAND_W-1:0] new_v,
                                                input logic [BAND_W-1:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction
endpackage

// File: rtl/dma_rg_gate.sv
module dma_rg_gate
  import dma_rg_pkg::*;
(
  input  logic [NSUB-1:0]   en,
  input  logic [1:0]        fa,
  input  logic              is_eng,
  output logic [NSUB-1:0]   band_perm,
  output logic [BAND_W-1:0] band_mask,
  output logic [NSUB-1:0]   ctrl_ok
);
  always_comb begin
    band_perm = sub_perm(en, fa);
    band_mask = is_eng ? band_eng_mask(band_perm) : '1;
    ctrl_ok   = is_eng ? en : '1;
  end
endmodule

// File: rtl/dma_rg_wen.sv
module dma_rg_wen
  import dma_rg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_wr,
  input  logic [WEN_W-1:0] wdata,
  output logic [WEN_W-1:0] q
);
  logic [NSUB-1:0] en_r;
  always_ff @(posedge clk) begin
    if (!rst_n)      en_r <= '0;
    else if (cpu_wr) en_r <= wdata[NSUB-1:0];
  end
  assign q = {{(WEN_W-NSUB){1'b0}}, en_r};
endmodule

// File: rtl/dma_rg_xfer.sv
module dma_rg_xfer
  import dma_rg_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] q [NSUB*XREGS]
);
  for (genvar i = 0; i < NSUB*XREGS; i++) begin : g_reg
    localparam logic [AW-1:0] MY_A = AW'(A_XFER0 + i);
    always_ff @(posedge clk) begin
      if (!rst_n)                          q[i] <= '0;
      else if (wr_en && wr_addr == MY_A)   q[i] <= wr_data;
    end
  end
endmodule

// File: rtl/dma_regguard.sv
module dma_regguard
  import dma_rg_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 5,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_eng,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam logic [AW-1:0] AB = AW'(A_BAND);
  localparam logic [AW-1:0] AE = AW'(A_WEN);

  logic [BAND_W-1:0] band_q;
  logic [WEN_W-1:0]  wen_q;
  logic [CW-1:0]     ctrl_q [NSUB];
  logic [DW-1:0]     xfer_q [NSUB*XREGS];
  logic [NSUB-1:0]   band_perm;
  logic [BAND_W-1:0] band_mask;
  logic [NSUB-1:0]   ctrl_ok;
  logic              band_hit, wen_cpu_hit;

  assign band_hit    = wr_en && wr_addr == AB;
  assign wen_cpu_hit = wr_en && !wr_eng && wr_addr == AE;

  dma_rg_gate u_gate (
    .en(wen_q[NSUB-1:0]), .fa(band_q[15:14]), .is_eng(wr_eng),
    .band_perm(band_perm), .band_mask(band_mask), .ctrl_ok(ctrl_ok)
  );

  dma_rg_wen u_wen (
    .clk(clk), .rst_n(rst_n), .cpu_wr(wen_cpu_hit),
    .wdata(wr_data[WEN_W-1:0]), .q(wen_q)
  );

  dma_rg_xfer #(.DW(DW), .AW(AW)) u_xfer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .q(xfer_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        band_q <= '0;
    else if (band_hit) band_q <= merge16(band_q, wr_data[BAND_W-1:0], band_mask);
  end

  for (genvar k = 0; k < NSUB; k++) begin : g_ctrl
    localparam logic [AW-1:0] MY_A = AW'(A_CTRL0 + k);
    always_ff @(posedge clk) begin
      if (!rst_n) ctrl_q[k] <= '0;
      else if (wr_en && wr_addr == MY_A && ctrl_ok[k]) ctrl_q[k] <= wr_data[CW-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == AB) rd_data = DW'(band_q);
    if (rd_addr == AE) rd_data = DW'(wen_q);
    for (int k = 0; k < NSUB; k++)
      if (rd_addr == AW'(A_CTRL0 + k)) rd_data = DW'(ctrl_q[k]);
    for (int i = 0; i < NSUB*XREGS; i++)
      if (rd_addr == AW'(A_XFER0 + i)) rd_data = xfer_q[i];
  end
endmodule

// File: rtl/dma_regguard_chk.sv
module dma_regguard_chk
  import dma_rg_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_eng,
  input logic [AW-1:0]     wr_addr,
  input logic [DW-1:0]     wr_data,
  input logic [BAND_W-1:0] band_q,
  input logic [WEN_W-1:0]  wen_q
);
  localparam logic [AW-1:0] AB = AW'(A_BAND);
  localparam logic [AW-1:0] AE = AW'(A_WEN);

  // R2
  wen_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wen_q[7:4] == 4'h0);
  // R6
  eng_mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_eng && wr_addr == AB) |=> $stable(band_q[15:12]));
  // R9
  eng_wen_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_eng && wr_addr == AE) |=> $stable(wen_q));
  // R4
  eng_band_deny0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_eng && wr_addr == AB && !wen_q[0])
      |=> $stable({band_q[8], band_q[4], band_q[0]}));
  // R7
  cpu_band_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_eng && wr_addr == AB) |=> band_q == $past(wr_data[BAND_W-1:0]));
endmodule

bind dma_regguard dma_regguard_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_eng(wr_eng),
  .wr_addr(wr_addr), .wr_data(wr_data), .band_q(band_q), .wen_q(wen_q)
);

// File: tb/tb_dma_regguard.sv
module tb_dma_regguard;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 5;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          wr_en = 0, wr_eng = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_regguard dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_eng(wr_eng),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input bit eng, input int a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_eng = eng; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_eng = 0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] v);
    rd_addr = AW'(a); #1; v = rd_data;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v, exp;
    logic [3:0] pen;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 20; a++) begin
      rd(a, v); chk($sformatf("R1 reset addr %0d", a), v, '0);
    end
    // R7: CPU writes unfiltered
    wr(0, 0, 16'hFFFF); rd(0, v); chk("R7 cpu band", v, 16'hFFFF);
    for (int k = 0; k < 4; k++) begin
      wr(0, 2+k, 16'h00FF); rd(2+k, v); chk("R7 cpu ctrl", v, 16'h00FF);
    end
    for (int en = 0; en < 16; en++) begin
      for (int fa = 0; fa < 4; fa++) begin
        // bench permission model
        for (int k = 0; k < 4; k++) begin
          int c;
          bit both;
          c = k / 2;
          both = en[2*c] && en[2*c+1];
          pen[k] = en[k] && (!fa[c] || both);
        end
        exp = {fa[1:0], 2'b10, 12'h000};
        wr(0, 0, exp);
        for (int k = 0; k < 4; k++) wr(0, 2+k, 16'h0000);
        wr(0, 1, 16'h00F0 | 16'(en));
        rd(1, v); chk("R2 wen readback", v, 16'(en));
        wr(1, 1, 16'h0000);
        rd(1, v); chk("R9 engine wen write ignored", v, 16'(en));
        // engine all-ones to band
        wr(1, 0, 16'hFFFF);
        for (int b = 0; b < 12; b++) if (pen[b % 4]) exp[b] = 1'b1;
        rd(0, v); chk($sformatf("R4/R5/R6 band en=%0d fa=%0d", en, fa), v, exp);
        chk("R10 xfer-enable bits", {12'h0, v[7:4]}, {12'h0, pen});
        // engine all-zeros clears only permitted bits
        wr(1, 0, 16'h0000);
        for (int b = 0; b < 12; b++) if (pen[b % 4]) exp[b] = 1'b0;
        rd(0, v); chk("R4 band clear", v, exp);
        for (int k = 0; k < 4; k++) begin
          wr(1, 2+k, 16'hFFFF);
          rd(2+k, v); chk($sformatf("R3 ctrl k=%0d en=%0d", k, en), v, en[k] ? 16'h00FF : 16'h0000);
        end
        begin
          int a;
          logic [DW-1:0] d;
          a = 8 + ((en*4 + fa) % 12);
          d = 16'hA5C0 ^ 16'(en*4 + fa);
          wr(fa[0], a, d);
          rd(a, v); chk("R8 address/count reg", v, d);
        end
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule